// File: doc/BRIEF.md
# Nibble-split constant-coefficient multiplier

This block multiplies an unsigned 8-bit sample by a coefficient fixed at elaboration, using no multiplier array. The sample is cut into two 4-bit halves. Each half addresses its own 16-entry table, and every entry of that table holds the half's value times the coefficient. The two table words are aligned four bits apart and added, which gives the 16-bit product.

The coefficient lives only in the table contents. Changing it regenerates the tables and leaves the datapath as it is. An optional register stage captures the product and the valid strobe. Without that stage the block is purely combinational from sample to product.

Top module: `nibble_const_mult`

## Requirements
- R1: With the register stage on, when `in_valid` was 1 at a rising edge, `out_product` after that edge equals `in_sample` times the coefficient, as an unsigned 16-bit value, for all 256 sample values.
- R2: Each table holds 16 entries of 12 bits, and entry k equals k times the coefficient. A sample whose upper half is 0 yields the lower-table entry. A sample k<<4 yields the upper-table entry shifted left by 4.
- R3: Product bits 3:0 equal bits 3:0 of (sample bits 3:0 times the coefficient) and pass through no adder.
- R4: Product bits 15:4 are the sum of the upper-table entry and the lower-table entry shifted right by 4. This sum never carries past 12 bits, so 255 x 255 gives 65025.
- R5: The coefficient comes only from a parameter. With coefficient 0 the product is 0 for every sample.
- R6: With the register stage on, `out_valid` equals the `in_valid` of the previous rising edge, and the product shown with it belongs to that same sample.
- R7: With the register stage on, `out_product` keeps its value across an edge at which `in_valid` is 0.
- R8: While `rst_n` is 0, the registered `out_valid` and `out_product` are 0.
- R9: With the register stage off, `out_valid` equals `in_valid`, and `out_product` equals `in_sample` times the coefficient in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks `in_sample` as a sample to multiply |
| in_sample | input | 8 | Unsigned input sample |
| out_valid | output | 1 | Marks `out_product` as a fresh product |
| out_product | output | 16 | Unsigned product of sample and coefficient |

## Verification
The assertions check on every cycle that the table-built product matches a true multiply for the sample present. They also check that the low four bits match, that the 12-bit adder never carries out, and, in registered mode, that the valid strobe and product trail the input by one edge and that the product holds when no sample arrives. Some behaviours can only be shown by the bench's scenarios. These are full coverage of all 256 samples, behaviour across different coefficient values (0, 255 and two others), the combinational variant, the reset values, and the directed per-table probes with one half of the sample held at zero.

// File: rtl/mulk_pkg.sv
`timescale 1ns/1ps
package mulk_pkg;
  // Value of one table entry: nibble index times coefficient.
  function automatic int unsigned part_product(input int unsigned idx, input int unsigned coef);
    return idx * coef;
  endfunction

  // Mask a coefficient to its declared width.
  function automatic int unsigned fit_coef(input int unsigned coef, input int unsigned width);
    return coef & ((32'd1 << width) - 32'd1);
  endfunction
endpackage

// File: rtl/mulk_nibble_table.sv
`timescale 1ns/1ps
module mulk_nibble_table #(
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned COEF   = 173
) (
  input  logic [NIB_W-1:0]        addr,
  output logic [NIB_W+COEF_W-1:0] entry
);
  localparam int unsigned DEPTH   = 1 << NIB_W;
  localparam int unsigned ENTRY_W = NIB_W + COEF_W;
  localparam int unsigned COEF_M  = mulk_pkg::fit_coef(COEF, COEF_W);

  logic [ENTRY_W-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_q[g] = ENTRY_W'(mulk_pkg::part_product(g, COEF_M));
  end

  assign entry = table_q[addr];
endmodule

// File: rtl/mulk_shift_add.sv
`timescale 1ns/1ps
module mulk_shift_add #(
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned ENTRY_W = 12
) (
  input  logic [ENTRY_W-1:0]       hi_entry,
  input  logic [ENTRY_W-1:0]       lo_entry,
  output logic [ENTRY_W+NIB_W-1:0] product,
  output logic                     adder_carry
);
  logic [ENTRY_W:0]   upper_sum;
  logic [ENTRY_W-1:0] lo_aligned;
  logic [NIB_W-1:0]   pass_bits;

  assign lo_aligned  = lo_entry >> NIB_W;
  assign upper_sum   = {1'b0, hi_entry} + {1'b0, lo_aligned};
  assign pass_bits   = lo_entry[NIB_W-1:0];
  assign adder_carry = upper_sum[ENTRY_W];
  assign product     = {upper_sum[ENTRY_W-1:0], pass_bits};
endmodule

// File: rtl/nibble_const_mult.sv
`timescale 1ns/1ps
module nibble_const_mult #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned COEF_W  = 8,
  parameter int unsigned COEF    = 173,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_sample,
  output logic                     out_valid,
  output logic [DATA_W+COEF_W-1:0] out_product
);
  localparam int unsigned NIB_W   = DATA_W / 2;
  localparam int unsigned ENTRY_W = NIB_W + COEF_W;
  localparam int unsigned PROD_W  = DATA_W + COEF_W;
  localparam int unsigned COEF_M  = mulk_pkg::fit_coef(COEF, COEF_W);

  logic [ENTRY_W-1:0] hi_entry, lo_entry;
  logic [PROD_W-1:0]  raw_product;
  logic               adder_carry;
  logic [PROD_W-1:0]  mult_ref;
  logic [NIB_W-1:0]   low_ref;

  mulk_nibble_table #(.NIB_W(NIB_W), .COEF_W(COEF_W), .COEF(COEF_M)) u_hi_tab (
    .addr(in_sample[DATA_W-1:NIB_W]), .entry(hi_entry));

  mulk_nibble_table #(.NIB_W(NIB_W), .COEF_W(COEF_W), .COEF(COEF_M)) u_lo_tab (
    .addr(in_sample[NIB_W-1:0]), .entry(lo_entry));

  mulk_shift_add #(.NIB_W(NIB_W), .ENTRY_W(ENTRY_W)) u_comb (
    .hi_entry(hi_entry), .lo_entry(lo_entry),
    .product(raw_product), .adder_carry(adder_carry));

  // Independent references used only by the checks below.
  assign mult_ref = PROD_W'(in_sample * COEF_M);
  assign low_ref  = NIB_W'(in_sample[NIB_W-1:0] * COEF_M);

  // R1
  table_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_product == mult_ref);

  // R3
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_product[NIB_W-1:0] == low_ref);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adder_carry);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid   <= 1'b0;
        out_product <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) out_product <= raw_product;
      end
    end

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

    // R6
    reg_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid) |-> out_product == $past(mult_ref));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> $stable(out_product));
  end else begin : g_comb
    assign out_valid   = in_valid;
    assign out_product = raw_product;

    // R9
    comb_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (out_product == mult_ref));
  end
endmodule

// File: tb/nibble_const_mult_tb_top.sv
`timescale 1ns/1ps
module nibble_const_mult_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_sample = 8'd0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  logic v_a, v_b, v_c, v_d;
  logic [15:0] p_a, p_b, p_c, p_d;

  nibble_const_mult #(.COEF(173), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(v_a), .out_product(p_a));
  nibble_const_mult #(.COEF(255), .REG_OUT(1'b1)) u_c255 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(v_b), .out_product(p_b));
  nibble_const_mult #(.COEF(0), .REG_OUT(1'b1)) u_c0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(v_c), .out_product(p_c));
  nibble_const_mult #(.COEF(99), .REG_OUT(1'b0)) u_comb99 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(v_d), .out_product(p_d));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference for the registered instances.
  int e_valid, e173, e255, e0;
  bit prev_idle;
  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid = 0; e173 = 0; e255 = 0; e0 = 0; prev_idle = 1'b0;
    end else begin
      e_valid = in_valid;
      prev_idle = !in_valid;
      if (in_valid) begin
        e173 = int'(in_sample) * 173;
        e255 = int'(in_sample) * 255;
        e0   = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 valid c173", int'(v_a), e_valid);
      chk("R6 valid c255", int'(v_b), e_valid);
      if (prev_idle) begin
        chk("R7 hold c173", int'(p_a), e173);
        chk("R7 hold c255", int'(p_b), e255);
      end else begin
        chk("R1 product c173", int'(p_a), e173);
        chk("R1 product c255", int'(p_b), e255);
      end
      chk("R5 coef zero", int'(p_c), e0);
      chk("R9 comb valid", int'(v_d), int'(in_valid));
      chk("R9 comb product", int'(p_d), int'(in_sample) * 99);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic drive(input bit v, input int s);
    @(posedge clk); #1;
    in_valid = v;
    in_sample = 8'(s);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset valid", int'(v_a), 0);
    chk("R8 reset product", int'(p_a), 0);
    chk("R8 reset product c255", int'(p_b), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // Full sweep on every instance.
    for (int s = 0; s < 256; s++) drive(1'b1, s);

    // Gapped traffic: samples change while valid is low.
    for (int i = 0; i < 40; i++) drive((i % 3) == 0, (i * 37 + 11) & 255);

    // R2: probe each table on the combinational instance.
    for (int k = 0; k < 16; k++) begin
      drive(1'b1, k);
      #0.5;
      chk("R2 lower table", int'(p_d), k * 99);
      drive(1'b1, k << 4);
      #0.5;
      chk("R2 upper table", int'(p_d), (k * 99) << 4);
    end

    // R3: low product bits.
    for (int i = 0; i < 16; i++) begin
      drive(1'b1, i * 17 + 3);
      #0.5;
      chk("R3 low bits", int'(p_d[3:0]), (((i * 17 + 3) & 15) * 99) & 15);
    end

    // R4: largest products.
    drive(1'b1, 255);
    drive(1'b0, 0);
    @(negedge clk);
    chk("R4 max c255", int'(p_b), 65025);
    chk("R4 max c173", int'(p_a), 44115);
    drive(1'b1, 8'hF0);
    drive(1'b0, 0);
    @(negedge clk);
    chk("R4 upper only c255", int'(p_b), 240 * 255);

    repeat (3) drive(1'b0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule